// File: doc/BRIEF.md
# Reversed-Order GPIO Port Register Block

This block is a bank of general-purpose I/O lines controlled through four word-wide registers on a single-cycle bus. Each line can be set as an input or an output. An output line can drive in push-pull or open-drain fashion. An input line passes its pad value to the readable data word only when that line's input buffer is switched on. Pad inputs are resynchronised to the block clock before use. The pad outputs and enables come from registers, and so does the read data.

Line n is controlled by bit (LINES-1-n) of every register word, so line 0 is the word's most significant bit. The pad vectors themselves are indexed by line number. A parameter fixes a group of four lines as input-only: either the highest-numbered lines or the lowest-numbered ones. The direction bits of those lines can never be set.

Top module: `pin_bank`

## Requirements
- R1: Byte offsets select the registers: 0x00 direction, 0x04 open-drain, 0x08 data, 0x18 input-buffer enable. A write with `bus_we` high stores `bus_wdata` at the clock edge. `bus_rdata` is registered: an address held during a cycle returns, after the next edge, the register contents from before that edge.
- R2: Pad line n (`pad_in[n]`, `pad_out[n]`, `pad_oe[n]`) is controlled by bit 31-n of every register, so line 0 is bit 31.
- R3: A direction bit of 1 makes the line a push-pull output (`pad_oe`=1, `pad_out`=data latch). A direction bit of 0 gives `pad_oe`=0 and `pad_out`=0. Pad outputs follow register contents one clock edge after the register changes.
- R4: In a data register read, an input line's bit is its synchronised pad value ANDed with its input-buffer-enable bit. A pad change present before edge k is first stored in the read data at edge k+2.
- R5: With the default parameter setting, lines 28..31 (bits 3..0) are input-only. Writes of 1 to their direction bits are ignored, those bits read 0, and their `pad_oe` is always 0. The other setting fixes lines 0..3 (bits 31..28) instead.
- R6: In a data register read, an output line's bit returns its data latch.
- R7: An output line whose open-drain bit is 1 drives low (`pad_oe`=1, `pad_out`=0) when its latch is 0. It releases the pad (`pad_oe`=0, `pad_out`=0) when its latch is 1.
- R8: After synchronous reset, direction, open-drain and data are all zero and input-buffer enable is all ones.
- R9: Reads of any other offset return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | LINES | Write data word |
| bus_rdata | output | LINES | Registered read data word |
| pad_in | input | LINES | Pad input values, index = line number |
| pad_out | output | LINES | Pad output values, index = line number |
| pad_oe | output | LINES | Pad output enables, index = line number |

## Verification
Three delays matter here. A register write changes the pads one edge after the write edge. A read returns data one edge after its address is presented. A pad change reaches the read data at the second edge after it, so it can be seen by a read issued two cycles later. The bench's reference model applies exactly these delays at every rising edge and compares all outputs at the following falling edge. The directed checks wait the matching number of falling edges before sampling.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;

  typedef enum logic [1:0] {
    FIX_NONE       = 2'd0,
    FIX_HIGH_LINES = 2'd1,
    FIX_LOW_LINES  = 2'd2
  } fixed_in_e;

  localparam logic [7:0] OFF_DIR  = 8'h00;
  localparam logic [7:0] OFF_ODR  = 8'h04;
  localparam logic [7:0] OFF_DATA = 8'h08;
  localparam logic [7:0] OFF_IBE  = 8'h18;

  localparam int unsigned MAX_LINES = 64;

  // Mask indexed by line number: bit n set when line n is input-only.
  function automatic logic [MAX_LINES-1:0] fixed_line_mask(
      fixed_in_e sel, int unsigned lines, int unsigned cnt);
    logic [MAX_LINES-1:0] m;
    m = '0;
    for (int unsigned n = 0; n < lines; n++) begin
      if (sel == FIX_HIGH_LINES && n >= lines - cnt) m[n] = 1'b1;
      if (sel == FIX_LOW_LINES && n < cnt) m[n] = 1'b1;
    end
    return m;
  endfunction

  // Same set expressed in register bit order (line n -> bit lines-1-n).
  function automatic logic [MAX_LINES-1:0] fixed_bit_mask(
      fixed_in_e sel, int unsigned lines, int unsigned cnt);
    logic [MAX_LINES-1:0] l;
    logic [MAX_LINES-1:0] b;
    l = fixed_line_mask(sel, lines, cnt);
    b = '0;
    for (int unsigned n = 0; n < lines; n++) b[lines-1-n] = l[n];
    return b;
  endfunction

endpackage

// File: rtl/pin_bank_sync.sv
module pin_bank_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pin_bank_regs.sv
module pin_bank_regs
  import pin_bank_pkg::*;
#(
  parameter int unsigned     LINES    = 32,
  parameter int unsigned     ADDR_W   = 8,
  parameter logic [LINES-1:0] FIX_BITS = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [LINES-1:0]  wdata,
  input  logic [LINES-1:0]  in_bits,
  output logic [LINES-1:0]  dir_q,
  output logic [LINES-1:0]  odr_q,
  output logic [LINES-1:0]  dat_q,
  output logic [LINES-1:0]  ibe_q,
  output logic [LINES-1:0]  rdata
);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFF_DIR);
  localparam logic [ADDR_W-1:0] A_ODR  = ADDR_W'(OFF_ODR);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_IBE  = ADDR_W'(OFF_IBE);

  logic [LINES-1:0] rd_next;
  logic [LINES-1:0] data_view;

  // Outputs show their latch; inputs show the gated synchronised pad.
  assign data_view = (dir_q & dat_q) | (~dir_q & ibe_q & in_bits);

  always_comb begin
    case (addr)
      A_DIR:   rd_next = dir_q;
      A_ODR:   rd_next = odr_q;
      A_DATA:  rd_next = data_view;
      A_IBE:   rd_next = ibe_q;
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      odr_q <= '0;
      dat_q <= '0;
      ibe_q <= '1;
      rdata <= '0;
    end else begin
      rdata <= rd_next;
      if (we) begin
        case (addr)
          A_DIR:   dir_q <= wdata & ~FIX_BITS;
          A_ODR:   odr_q <= wdata;
          A_DATA:  dat_q <= wdata;
          A_IBE:   ibe_q <= wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pin_bank_drive.sv
module pin_bank_drive #(
  parameter int unsigned LINES = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] dir_q,
  input  logic [LINES-1:0] odr_q,
  input  logic [LINES-1:0] dat_q,
  output logic [LINES-1:0] pad_out,
  output logic [LINES-1:0] pad_oe
);
  generate
    for (genvar n = 0; n < LINES; n++) begin : g_line
      localparam int unsigned B = LINES - 1 - n;
      logic oe_d;
      logic out_d;
      // Open-drain drives only a low level; push-pull drives the latch.
      assign oe_d  = dir_q[B] & (~odr_q[B] | ~dat_q[B]);
      assign out_d = dir_q[B] & ~odr_q[B] & dat_q[B];
      always_ff @(posedge clk) begin
        if (rst) begin
          pad_oe[n]  <= 1'b0;
          pad_out[n] <= 1'b0;
        end else begin
          pad_oe[n]  <= oe_d;
          pad_out[n] <= out_d;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pin_bank.sv
module pin_bank
  import pin_bank_pkg::*;
#(
  parameter int unsigned LINES          = 32,
  parameter int unsigned ADDR_W         = 8,
  parameter fixed_in_e   FIXED_IN       = FIX_HIGH_LINES,
  parameter int unsigned FIXED_IN_COUNT = 4,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [LINES-1:0]  bus_wdata,
  output logic [LINES-1:0]  bus_rdata,
  input  logic [LINES-1:0]  pad_in,
  output logic [LINES-1:0]  pad_out,
  output logic [LINES-1:0]  pad_oe
);
  localparam logic [MAX_LINES-1:0] FIX_ALL =
      fixed_bit_mask(FIXED_IN, LINES, FIXED_IN_COUNT);
  localparam logic [LINES-1:0] FIX_BITS = FIX_ALL[LINES-1:0];

  logic [LINES-1:0] sync_lines;
  logic [LINES-1:0] sync_bits;
  logic [LINES-1:0] dir_q, odr_q, dat_q, ibe_q;

  pin_bank_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (sync_lines)
  );

  // Line order to register bit order.
  generate
    for (genvar n = 0; n < LINES; n++) begin : g_rev
      assign sync_bits[LINES-1-n] = sync_lines[n];
    end
  endgenerate

  pin_bank_regs #(.LINES(LINES), .ADDR_W(ADDR_W), .FIX_BITS(FIX_BITS)) i_regs (
    .clk     (clk),
    .rst     (rst),
    .addr    (bus_addr),
    .we      (bus_we),
    .wdata   (bus_wdata),
    .in_bits (sync_bits),
    .dir_q   (dir_q),
    .odr_q   (odr_q),
    .dat_q   (dat_q),
    .ibe_q   (ibe_q),
    .rdata   (bus_rdata)
  );

  pin_bank_drive #(.LINES(LINES)) i_drive (
    .clk     (clk),
    .rst     (rst),
    .dir_q   (dir_q),
    .odr_q   (odr_q),
    .dat_q   (dat_q),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );
endmodule

// File: rtl/pin_bank_chk.sv
module pin_bank_chk
  import pin_bank_pkg::*;
#(
  parameter int unsigned LINES          = 32,
  parameter int unsigned ADDR_W         = 8,
  parameter fixed_in_e   FIXED_IN       = FIX_HIGH_LINES,
  parameter int unsigned FIXED_IN_COUNT = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [LINES-1:0]  bus_rdata,
  input logic [LINES-1:0]  pad_out,
  input logic [LINES-1:0]  pad_oe
);
  localparam logic [MAX_LINES-1:0] LM = fixed_line_mask(FIXED_IN, LINES, FIXED_IN_COUNT);
  localparam logic [MAX_LINES-1:0] BM = fixed_bit_mask(FIXED_IN, LINES, FIXED_IN_COUNT);
  localparam logic [LINES-1:0] LINE_M = LM[LINES-1:0];
  localparam logic [LINES-1:0] BIT_M  = BM[LINES-1:0];

  logic mapped;
  assign mapped = (bus_addr == ADDR_W'(OFF_DIR)) || (bus_addr == ADDR_W'(OFF_ODR)) ||
                  (bus_addr == ADDR_W'(OFF_DATA)) || (bus_addr == ADDR_W'(OFF_IBE));

  // R5
  fixed_line_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & LINE_M) == '0);

  // R5
  fixed_dir_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_addr) == ADDR_W'(OFF_DIR) |-> (bus_rdata & BIT_M) == '0);

  // R9
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(mapped) |-> bus_rdata == '0);

  // R7
  high_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_out & ~pad_oe) == '0);
endmodule

bind pin_bank pin_bank_chk #(
  .LINES(LINES), .ADDR_W(ADDR_W), .FIXED_IN(FIXED_IN), .FIXED_IN_COUNT(FIXED_IN_COUNT)
) i_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/test_pin_bank.sv
`timescale 1ns/1ps
module test_pin_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pin_bank i_pin_bank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // Reference model state, indexed by line number.
  logic [31:0] m_dir, m_odr, m_dat, m_ibe, m_s1, m_s2;
  logic [31:0] e_rdata, e_out, e_oe;
  localparam logic [31:0] FIXED_LINES = 32'hF000_0000; // lines 28..31

  function automatic logic [31:0] flip(input logic [31:0] v);
    logic [31:0] r;
    for (int n = 0; n < 32; n++) r[31-n] = v[n];
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_dir = '0; m_odr = '0; m_dat = '0; m_ibe = '1; m_s1 = '0; m_s2 = '0;
      e_rdata = '0; e_out = '0; e_oe = '0;
    end else begin
      for (int n = 0; n < 32; n++) begin
        if (!m_dir[n])      begin e_oe[n] = 0; e_out[n] = 0; end
        else if (m_odr[n])  begin e_oe[n] = !m_dat[n]; e_out[n] = 0; end
        else                begin e_oe[n] = 1; e_out[n] = m_dat[n]; end
      end
      case (bus_addr)
        8'h00: e_rdata = flip(m_dir);
        8'h04: e_rdata = flip(m_odr);
        8'h18: e_rdata = flip(m_ibe);
        8'h08: begin
          logic [31:0] v;
          for (int n = 0; n < 32; n++)
            v[n] = m_dir[n] ? m_dat[n] : (m_ibe[n] & m_s2[n]);
          e_rdata = flip(v);
        end
        default: e_rdata = '0;
      endcase
      if (bus_we) begin
        case (bus_addr)
          8'h00: m_dir = flip(bus_wdata) & ~FIXED_LINES;
          8'h04: m_odr = flip(bus_wdata);
          8'h08: m_dat = flip(bus_wdata);
          8'h18: m_ibe = flip(bus_wdata);
          default: ;
        endcase
      end
      m_s2 = m_s1;
      m_s1 = pad_in;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R1 R4 R6 R9 read data vs model", bus_rdata, e_rdata);
      check("R2 R3 R7 pad_out vs model", pad_out, e_out);
      check("R3 R5 R7 pad_oe vs model", pad_oe, e_oe);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8 reset values
    rd(8'h00, v); check("R8 direction after reset", v, 32'h0);
    rd(8'h04, v); check("R8 open-drain after reset", v, 32'h0);
    rd(8'h08, v); check("R8 data after reset", v, 32'h0);
    rd(8'h18, v); check("R8 input enable after reset", v, 32'hFFFF_FFFF);
    check("R8 pad_oe after reset", pad_oe, 32'h0);
    // R1 map and readback
    wr(8'h04, 32'h1234_5670); rd(8'h04, v); check("R1 open-drain readback", v, 32'h1234_5670);
    wr(8'h04, 32'h0);
    wr(8'h18, 32'hA5A5_A5A5); rd(8'h18, v); check("R1 input enable readback", v, 32'hA5A5_A5A5);
    wr(8'h18, 32'hFFFF_FFFF);
    // R5 input-only lines
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); check("R5 fixed direction bits", v, 32'hFFFF_FFF0);
    check("R5 fixed lines never enabled", pad_oe & 32'hF000_0000, 32'h0);
    // R2 line 0 is bit 31
    wr(8'h00, 32'h8000_0000); wr(8'h08, 32'h8000_0000);
    @(negedge clk);
    check("R2 R3 line0 drives", pad_out, 32'h0000_0001);
    check("R2 R3 line0 enabled", pad_oe, 32'h0000_0001);
    // R6 output read-back, R4 input path on line 1 (bit 30)
    rd(8'h08, v); check("R6 output latch read", v, 32'h8000_0000);
    pad_in = 32'h0000_0002;
    @(negedge clk); @(negedge clk);
    rd(8'h08, v); check("R4 synced input visible", v, 32'hC000_0000);
    wr(8'h18, 32'hBFFF_FFFF);
    rd(8'h08, v); check("R4 input gated by enable", v, 32'h8000_0000);
    wr(8'h18, 32'hFFFF_FFFF);
    // R7 open drain on line 0
    wr(8'h04, 32'h8000_0000); @(negedge clk);
    check("R7 released when latch 1", pad_oe, 32'h0);
    wr(8'h08, 32'h0); @(negedge clk);
    check("R7 drives low oe", pad_oe, 32'h0000_0001);
    check("R7 drives low value", pad_out, 32'h0);
    // R3 input line not driven
    wr(8'h00, 32'h0); @(negedge clk);
    check("R3 input line released", pad_oe, 32'h0);
    // R9 unmapped
    wr(8'h0C, 32'hFFFF_FFFF); wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h0C, v); check("R9 unmapped read", v, 32'h0);
    rd(8'h00, v); check("R9 direction untouched", v, 32'h0);
    rd(8'h04, v); check("R9 open-drain untouched", v, 32'h8000_0000);
    // Mixed traffic against the model
    for (int i = 0; i < 600; i++) begin
      logic [2:0] sel;
      sel = 3'($urandom_range(0, 5));
      case (sel)
        3'd0: bus_addr = 8'h00;
        3'd1: bus_addr = 8'h04;
        3'd2: bus_addr = 8'h08;
        3'd3: bus_addr = 8'h18;
        3'd4: bus_addr = 8'h0C;
        default: bus_addr = 8'h1C;
      endcase
      bus_we = ($urandom_range(0, 2) == 0);
      bus_wdata = $urandom;
      if ($urandom_range(0, 3) == 0) pad_in = $urandom;
      @(negedge clk);
    end
    bus_we = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule